// File: doc/BRIEF.md
# Shift-Register Reload Clock Divider

This block divides an input clock by a programmable integer without a binary counter. A state register walks a fixed pseudo-random shift sequence, one step per input clock. When it lands on a fixed end state it takes a stored start code back in and flips the divided output. The division ratio N therefore comes from the choice of start code: it is the sequence state that lies N-1 steps before the end state. A binary count is never formed, so the next-state logic is a few XNOR gates plus one equality compare.

A single parameter picks one of two sizes. The 6-bit size serves as a reference divider and covers ratios 1 to 64. The 8-bit size serves as a feedback divider and covers ratios 2 to 160. A load strobe captures a new start code and restarts the divided clock from low. Each end-state hit also raises a one-cycle tick. The divided output changes level every N input clocks, so one full output period lasts 2N input clocks.

Top module: `lfsr_reload_div`

## Requirements
- R1: While reset is held and right after it, div_out is 0 and tick is 1, because the state and stored code both sit at the end state. After release, div_out changes level on every clock edge until a load.
- R2: When load is high at a clock edge, the edge copies reload_code into the state and into the stored code, and div_out is 0 after that edge. Load wins over an end-state hit at the same edge.
- R3: If no load occurs, div_out changes level only at edges where the state is the end state. Stored code N gives N clock edges between successive level changes, and the first change comes N edges after the load edge.
- R4: In the 6-bit size, the state shifts toward the MSB each clock. The bit that enters the LSB is the XNOR of bits 5 and 4. State 0x00 steps to the end state 0x3f. As a result, codes 0x01, 0x1f and 0x3e give ratios 64, 60 and 59.
- R5: In the 6-bit size, code 0x3f gives ratio 1, 0x00 gives 2, 0x20 gives 3 and 0x28 gives 5.
- R6: In the 8-bit size, the state shifts toward the MSB each clock. The bit that enters the LSB is the XNOR of bits 7, 3, 2 and 1. The end state is 0x01. As a result, codes 0x2f, 0xfe and 0x69 give ratios 10, 26 and 160.
- R7: In the 8-bit size, code 0x00 gives ratio 2, 0x80 gives 3 and 0xc0 gives 4.
- R8: A change on reload_code while load is low has no effect on the division ratio.
- R9: tick is high for exactly one clock per interval, in the last cycle before each div_out level change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture reload_code and restart |
| reload_code | input | WIDTH | Start code: the state N-1 steps before the end state |
| div_out | output | 1 | Divided clock, changes level every N input clocks |
| tick | output | 1 | High while the state equals the end state |

## Verification
A corrupted state or stored code never shows up as a wrong value. It shows up as an interval of the wrong length: div_out changes level early or late, and tick moves with it. This becomes visible at the next end-state hit, at most N input clocks after the fault. A wrong feedback tap only affects start codes whose path runs through the faulty transition. For that reason the anchor codes are spread across both ends and the middle of each sequence, and each measured interval is compared with its known ratio.

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] reload_code,
  output logic             div_out,
  output logic             tick
);

  localparam logic [WIDTH-1:0] END_CODE = (WIDTH == 6) ? {WIDTH{1'b1}} : WIDTH'(1);

  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] hold;
  logic [WIDTH-1:0] stepped;
  logic             fb;

  generate
    if (WIDTH == 6) begin : g_six
      assign fb = ~(state[5] ^ state[4]);
    end else begin : g_eight
      assign fb = ~(state[7] ^ state[3] ^ state[2] ^ state[1]);
    end
  endgenerate

  assign tick    = (state == END_CODE);
  assign stepped = (state == '0) ? END_CODE : {state[WIDTH-2:0], fb};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= END_CODE;
      hold    <= END_CODE;
      div_out <= 1'b0;
    end else if (load) begin
      state   <= reload_code;
      hold    <= reload_code;
      div_out <= 1'b0;
    end else if (tick) begin
      state   <= hold;
      div_out <= ~div_out;
    end else begin
      state   <= stepped;
    end
  end

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!div_out && state == $past(reload_code)));

  // R3
  end_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (div_out != $past(div_out)));

  // R3
  no_stray_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(div_out));

  // R8
  reload_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (state == $past(hold)));

  // R8
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold));

endmodule

// File: tb/sim_lfsr_reload_div.sv
module sim_lfsr_reload_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld6 = 1'b0, ld8 = 1'b0;
  logic [5:0] code6 = '0;
  logic [7:0] code8 = '0;
  logic d6, t6, d8, t8;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lfsr_reload_div #(.WIDTH(6)) u0 (.clk(clk), .rst_n(rst_n), .load(ld6),
    .reload_code(code6), .div_out(d6), .tick(t6));
  lfsr_reload_div #(.WIDTH(8)) u1 (.clk(clk), .rst_n(rst_n), .load(ld8),
    .reload_code(code8), .div_out(d8), .tick(t8));

  function automatic logic dv(bit sel); return sel ? d8 : d6; endfunction
  function automatic logic tk(bit sel); return sel ? t8 : t6; endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(bit sel, int code, string req);
    if (sel) begin ld8 = 1'b1; code8 = 8'(code); end
    else begin ld6 = 1'b1; code6 = 6'(code); end
    @(posedge clk); @(negedge clk);
    ld6 = 1'b0; ld8 = 1'b0;
    check({req, " R2 low after load"}, int'(dv(sel)), 0);
  endtask

  task automatic measure(bit sel, int n, string req);
    for (int iv = 0; iv < 2; iv++) begin
      logic start = dv(sel);
      int k = 0, ticks = 0;
      logic last_tick = 1'b0;
      while (dv(sel) == start && k < 400) begin
        last_tick = tk(sel);
        if (last_tick) ticks++;
        @(posedge clk); @(negedge clk);
        k++;
      end
      check({req, " interval"}, k, n);
      check({req, " R9 tick count"}, ticks, 1);
      check({req, " R9 tick last"}, int'(last_tick), 1);
    end
  endtask

  task automatic ratio(bit sel, int code, int n, string req);
    do_load(sel, code, req);
    measure(sel, n, req);
  endtask

  task automatic scen_reset;
    check("R1 div_out in reset", int'(d6), 0);
    check("R1 tick in reset", int'(t6), 1);
    check("R1 div_out8 in reset", int'(d8), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 first flip", int'(d6), 1);
    @(posedge clk); @(negedge clk);
    check("R1 second flip", int'(d6), 0);
  endtask

  task automatic scen_six;
    ratio(0, 'h3f, 1, "R5 code3f");
    ratio(0, 'h00, 2, "R5 code00");
    ratio(0, 'h20, 3, "R5 code20");
    ratio(0, 'h28, 5, "R5 code28");
    ratio(0, 'h01, 64, "R4 code01");
    ratio(0, 'h1f, 60, "R4 code1f");
    ratio(0, 'h3e, 59, "R4 code3e");
  endtask

  task automatic scen_eight;
    ratio(1, 'h00, 2, "R7 code00");
    ratio(1, 'h80, 3, "R7 code80");
    ratio(1, 'hc0, 4, "R7 codec0");
    ratio(1, 'h2f, 10, "R6 code2f");
    ratio(1, 'hfe, 26, "R6 codefe");
    ratio(1, 'h69, 160, "R6 code69");
  endtask

  task automatic scen_restart;
    do_load(0, 'h01, "R2 restart");
    while (d6 == 1'b0) begin @(posedge clk); @(negedge clk); end
    repeat (5) begin @(posedge clk); @(negedge clk); end
    check("R2 high before reload", int'(d6), 1);
    ratio(0, 'h28, 5, "R2 mid-cycle");
    // R2: load on an end-state cycle (ratio 1 keeps tick high)
    do_load(0, 'h3f, "R2 prio setup");
    check("R2 tick before load", int'(t6), 1);
    ratio(0, 'h00, 2, "R2 prio");
  endtask

  task automatic scen_ignore;
    do_load(0, 'h20, "R8 setup");
    code6 = 6'h01;
    measure(0, 3, "R8 code change ignored");
    code6 = 6'h3f;
    measure(0, 3, "R8 code change ignored again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    scen_reset;
    scen_six;
    scen_eight;
    scen_restart;
    scen_ignore;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule